// File: doc/BRIEF.md
# Random Number Generator Peripheral

This block is a small memory-mapped random word source that sits on a simple 32-bit register bus. Software turns it on with a run bit in the control register. After a fixed delay the block captures a fresh 32-bit word from a xorshift engine into a single-word output holder, and the level field in the status register goes to one. Reading the output register hands back that word and empties the holder. Another word follows after the same delay.

The engine state starts from a nonzero seed. A free-running cycle counter is folded into the state when the run bit is first set, and any word that software writes to the entropy register is XORed into the state in the cycle of the write. Reading an empty holder is an underflow. It returns zero and raises three status flags with different clearing rules. The error flag drives an interrupt line unless it is masked. An optional assurance bit turns underflows into a security-violation flag that only reset removes. A control bit or an external doze pin puts the block to sleep, which freezes both the engine and the load timer.

Top module: `rng_periph`

## Requirements
- R1: After reset the status register (byte offset 0x4) reads 0x00010000, which is a level of 0 in bits 15:8 and a fixed size of 1 in bits 23:16. The control register (0x0) and the output register (0xC) read 0, and `err_irq` is low.
- R2: Control bit 0 (run) is sticky. Writing 0 to it does not clear it, and only reset does.
- R3: Exactly 32 clock edges after the edge that writes run=1, the holder loads and status bits 15:8 read 1. Before that edge they read 0.
- R4: A read of the output register while the level is 1 returns a nonzero word, and the level becomes 0. The next word is loaded 32 cycles later, and back-to-back words differ.
- R5: A read of the output register while the level is 0 returns 0 and sets status bits 3 (error), 2 (underflow) and 1 (last-read-underflowed).
- R6: A read of the status register clears bits 2 and 1 but leaves bit 3 set.
- R7: Writing 1 to control bit 3 clears status bit 3. Control bit 3 always reads back as 0.
- R8: `err_irq` is high exactly when status bit 3 is set and control bit 2 (mask) is 0.
- R9: Control bit 1 (assurance) is sticky until reset. While it is set, an underflow sets status bit 0, which stays set until reset. Without it, an underflow leaves bit 0 at 0.
- R10: Control bit 4 or the `doze_in` pin puts the block to sleep. Status bit 4 shows the sleep state, and no word is loaded while asleep.
- R11: The entropy register (0x8) reads 0. A write to it changes the words produced afterwards.
- R12: Status bit 1 reflects only the latest output read: a successful output read clears it, while status bit 2 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address. Bits 1:0 must be 0 for an access to take effect. |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_rdata | output | 32 | Read data, combinational from the address |
| doze_in | input | 1 | External sleep request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The checker assumes that the bus issues at most one access per cycle. It never sees a read and a write together, and the address and strobes stay stable through the clock edge at which they act. The interrupt property depends on the mask not being rewritten in the same cycle as the underflowing read. The bench meets these assumptions by driving every access on the falling edge and holding it for exactly one rising edge. Each access is a single read or a single write, and the control register is never written in the same cycle as an output read.

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;

    // control bit positions
    localparam int CTL_RUN    = 0;
    localparam int CTL_ASSURE = 1;
    localparam int CTL_MASK   = 2;
    localparam int CTL_CLRERR = 3;
    localparam int CTL_NAP    = 4;

    localparam logic [WORD_W-1:0] ZERO_FIX = 32'h6A09_E667;
    localparam logic [7:0]        HOLD_SIZE = 8'd1;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_ENT  = 2'd2,
        REG_OUT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic secv;
        logic lrs;
        logic oru;
        logic erri;
    } flags_t;

    function automatic logic [WORD_W-1:0] xs_step(input logic [WORD_W-1:0] s);
        logic [WORD_W-1:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] never_zero(input logic [WORD_W-1:0] s);
        return (s == '0) ? ZERO_FIX : s;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input flags_t f,
                                                      input logic   asleep,
                                                      input logic   full);
        return {8'h00, HOLD_SIZE, 7'h00, full, 3'b000, asleep,
                f.erri, f.oru, f.lrs, f.secv};
    endfunction

endpackage

// File: rtl/rng_engine.sv
module rng_engine
    import rng_pkg::*;
#(
    parameter logic [WORD_W-1:0] SEED = 32'hC0FF_EE01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              kick,
    input  logic              ent_valid,
    input  logic [WORD_W-1:0] ent_word,
    output logic [WORD_W-1:0] state
);

    logic [WORD_W-1:0] ticker;
    logic [WORD_W-1:0] stepped;
    logic [WORD_W-1:0] mixed;

    always_comb begin
        stepped = step_en ? xs_step(state) : state;
        mixed   = stepped;
        if (ent_valid) mixed = mixed ^ ent_word;
        if (kick)      mixed = mixed ^ ticker;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= never_zero(SEED);
            ticker <= '0;
        end else begin
            state  <= never_zero(mixed);
            ticker <= ticker + 1'b1;
        end
    end

endmodule

// File: rtl/rng_holder.sv
module rng_holder
    import rng_pkg::*;
#(
    parameter int LOAD_GAP = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              take,
    input  logic [WORD_W-1:0] fresh,
    output logic [WORD_W-1:0] word_q,
    output logic              full
);

    localparam int CW = (LOAD_GAP > 2) ? $clog2(LOAD_GAP) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOAD_GAP - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            full   <= 1'b0;
            word_q <= '0;
        end else if (take && full) begin
            full   <= 1'b0;
            word_q <= '0;
        end else if (run && !full) begin
            if (cnt == LAST) begin
                cnt    <= '0;
                full   <= 1'b1;
                word_q <= fresh;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rng_flags.sv
module rng_flags
    import rng_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   assure,
    input  logic   under,
    input  logic   good_rd,
    input  logic   stat_rd,
    input  logic   clr_err,
    output flags_t flg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg <= '0;
        end else begin
            if (under && assure) flg.secv <= 1'b1;

            if (under)                    flg.lrs <= 1'b1;
            else if (good_rd || stat_rd)  flg.lrs <= 1'b0;

            if (under)        flg.oru <= 1'b1;
            else if (stat_rd) flg.oru <= 1'b0;

            if (under)        flg.erri <= 1'b1;
            else if (clr_err) flg.erri <= 1'b0;
        end
    end

endmodule

// File: rtl/rng_periph.sv
module rng_periph
    import rng_pkg::*;
#(
    parameter int                LOAD_GAP = 32,
    parameter logic [WORD_W-1:0] SEED     = 32'hC0FF_EE01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              doze_in,
    output logic              err_irq
);

    reg_sel_e          sel;
    logic              aligned;
    logic              wr_ctrl, wr_ent, rd_stat, rd_out;
    logic              go_q, ha_q, intm_q, slp_q;
    logic              sleep_now, go_set;
    logic              full;
    logic [WORD_W-1:0] eng_state, word_q;
    flags_t            flags;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ctrl = bus_we && aligned && (sel == REG_CTRL);
    assign wr_ent  = bus_we && aligned && (sel == REG_ENT);
    assign rd_stat = bus_re && aligned && (sel == REG_STAT);
    assign rd_out  = bus_re && aligned && (sel == REG_OUT);

    assign sleep_now = slp_q | doze_in;
    assign go_set    = wr_ctrl && bus_wdata[CTL_RUN] && !go_q;

    // control: run and assure only ever set; clear-error is a pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= 1'b0;
            ha_q   <= 1'b0;
            intm_q <= 1'b0;
            slp_q  <= 1'b0;
        end else if (wr_ctrl) begin
            go_q   <= go_q | bus_wdata[CTL_RUN];
            ha_q   <= ha_q | bus_wdata[CTL_ASSURE];
            intm_q <= bus_wdata[CTL_MASK];
            slp_q  <= bus_wdata[CTL_NAP];
        end
    end

    rng_engine #(.SEED(SEED)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .step_en   (go_q && !sleep_now),
        .kick      (go_set),
        .ent_valid (wr_ent),
        .ent_word  (bus_wdata),
        .state     (eng_state)
    );

    rng_holder #(.LOAD_GAP(LOAD_GAP)) u_holder (
        .clk    (clk),
        .rst    (rst),
        .run    (go_q && !sleep_now),
        .take   (rd_out),
        .fresh  (eng_state),
        .word_q (word_q),
        .full   (full)
    );

    rng_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .assure  (ha_q),
        .under   (rd_out && !full),
        .good_rd (rd_out && full),
        .stat_rd (rd_stat),
        .clr_err (wr_ctrl && bus_wdata[CTL_CLRERR]),
        .flg     (flags)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                REG_CTRL: begin
                    bus_rdata[CTL_RUN]    = go_q;
                    bus_rdata[CTL_ASSURE] = ha_q;
                    bus_rdata[CTL_MASK]   = intm_q;
                    bus_rdata[CTL_NAP]    = slp_q;
                end
                REG_STAT: bus_rdata = pack_status(flags, sleep_now, full);
                REG_ENT:  bus_rdata = '0;
                REG_OUT:  bus_rdata = full ? word_q : '0;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign err_irq = flags.erri & ~intm_q;

endmodule

// File: rtl/rng_chk.sv
module rng_chk
    import rng_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              err_irq,
    input logic              go_q,
    input logic              ha_q,
    input logic              intm_q,
    input logic              sleep_now,
    input logic              full,
    input flags_t            flg
);

    logic out_rd, ctl_rd, ent_rd;
    assign out_rd = bus_re && (bus_addr == 4'hC);
    assign ctl_rd = bus_re && (bus_addr == 4'h0);
    assign ent_rd = bus_re && (bus_addr == 4'h8);

    assert_run_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        go_q |=> go_q);

    assert_assure_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ha_q |=> ha_q);

    assert_secv_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        flg.secv |=> flg.secv);

    assert_take_empties_R4: assert property (@(posedge clk) disable iff (rst)
        (out_rd && full) |=> !full);

    assert_under_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (out_rd && !full) |-> (bus_rdata == '0));

    assert_under_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (out_rd && !full && !intm_q && !bus_we) |=> err_irq);

    assert_no_load_asleep_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(go_q && !sleep_now));

    assert_clrerr_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_rd |-> !bus_rdata[CTL_CLRERR]);

    assert_entropy_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        ent_rd |-> (bus_rdata == '0));

endmodule

bind rng_periph rng_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .err_irq   (err_irq),
    .go_q      (go_q),
    .ha_q      (ha_q),
    .intm_q    (intm_q),
    .sleep_now (sleep_now),
    .full      (full),
    .flg       (flags)
);

// File: tb/sim_rng_periph.sv
module sim_rng_periph;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        doze = 1'b0;
    logic        err_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rng_periph u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .doze_in(doze), .err_irq(err_irq)
    );

    localparam logic [3:0] CT = 4'h0, ST = 4'h4, EN = 4'h8, OU = 4'hC;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] val;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, ST, 32'h0001_0000, 1'b0, 4'd1},   // R1
        '{1'b0, CT, 32'h0000_0000, 1'b0, 4'd1},   // R1
        '{1'b0, EN, 32'h0000_0000, 1'b0, 4'd11},  // R11
        '{1'b0, OU, 32'h0000_0000, 1'b0, 4'd5},   // R5 underflow
        '{1'b0, ST, 32'h0001_000E, 1'b1, 4'd5},   // R5
        '{1'b0, ST, 32'h0001_0008, 1'b1, 4'd6},   // R6
        '{1'b1, CT, 32'h0000_0008, 1'b1, 4'd7},   // R7 clear error
        '{1'b0, CT, 32'h0000_0000, 1'b0, 4'd7},   // R7
        '{1'b0, ST, 32'h0001_0000, 1'b0, 4'd7},   // R7
        '{1'b1, CT, 32'h0000_0004, 1'b0, 4'd8},   // R8 mask on
        '{1'b0, OU, 32'h0000_0000, 1'b0, 4'd8},   // R8
        '{1'b0, ST, 32'h0001_000E, 1'b0, 4'd8},   // R8 masked
        '{1'b0, CT, 32'h0000_0004, 1'b0, 4'd8},   // R8
        '{1'b1, CT, 32'h0000_0000, 1'b0, 4'd8},   // R8 mask off
        '{1'b0, ST, 32'h0001_0008, 1'b1, 4'd8},   // R8
        '{1'b1, CT, 32'h0000_0008, 1'b1, 4'd7},   // R7
        '{1'b0, ST, 32'h0001_0000, 1'b0, 4'd7},   // R7
        '{1'b1, CT, 32'h0000_0010, 1'b0, 4'd10},  // R10 sleep bit
        '{1'b0, ST, 32'h0001_0010, 1'b0, 4'd10},  // R10
        '{1'b0, CT, 32'h0000_0010, 1'b0, 4'd10},  // R10
        '{1'b1, CT, 32'h0000_0000, 1'b0, 4'd10},  // R10
        '{1'b0, ST, 32'h0001_0000, 1'b0, 4'd10}   // R10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] d, w1, w2, wa, wb;
        @(negedge clk);
        do_reset();

        // table walk: reset state, flags, interrupt, sleep bit
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            if (VECS[i].wr) begin
                #1 chk({tag, " irq"}, {31'b0, err_irq}, {31'b0, VECS[i].irq});
                wr(VECS[i].addr, VECS[i].val);
            end else begin
                #1 chk({tag, " irq"}, {31'b0, err_irq}, {31'b0, VECS[i].irq});
                rd(VECS[i].addr, d);
                chk({tag, " data"}, d, VECS[i].val);
            end
        end

        // R3: load exactly 32 edges after run is written
        wr(CT, 32'h1);
        idle(30);
        rd(ST, d); chk("R3 before", d, 32'h0001_0000);
        rd(ST, d); chk("R3 edge31", d, 32'h0001_0000);
        rd(ST, d); chk("R3 loaded", d, 32'h0001_0100);

        // R2: run is sticky
        wr(CT, 32'h0);
        rd(CT, d); chk("R2 sticky", d, 32'h1);

        // R4: take a word
        rd(OU, w1);
        chk("R4 nonzero", {31'b0, (w1 != 0)}, 32'h1);
        rd(ST, d); chk("R4 empty", d, 32'h0001_0000);

        // R12: underflow then a good read leaves only the underflow flag
        rd(OU, d); chk("R5 zero", d, 32'h0);
        idle(40);
        rd(OU, w2);
        chk("R4 nonzero2", {31'b0, (w2 != 0)}, 32'h1);
        chk("R4 differ", {31'b0, (w2 != w1)}, 32'h1);
        rd(ST, d); chk("R12 lrs", d, 32'h0001_000C);
        wr(CT, 32'h8);

        // R10: sleep bit and doze pin both stop loading
        wr(CT, 32'h11);
        idle(50);
        rd(ST, d); chk("R10 slept", d, 32'h0001_0010);
        doze = 1'b1;
        wr(CT, 32'h1);
        idle(50);
        rd(ST, d); chk("R10 doze", d, 32'h0001_0010);
        doze = 1'b0;
        idle(40);
        rd(ST, d); chk("R10 wake", d, 32'h0001_0100);

        // R9: no violation without assurance, sticky with it
        rd(OU, d);
        rd(OU, d);
        rd(ST, d); chk("R9 off", d, 32'h0001_000E);
        wr(CT, 32'h8);
        wr(CT, 32'h3);
        rd(OU, d);
        rd(ST, d); chk("R9 secv", d, 32'h0001_000F);
        wr(CT, 32'h0);
        rd(CT, d); chk("R9 assure sticky", d, 32'h3);
        wr(CT, 32'h8);
        rd(ST, d); chk("R9 secv stays", d, 32'h0001_0001);

        // R1: reset clears sticky state
        do_reset();
        rd(ST, d); chk("R1 after reset", d, 32'h0001_0000);
        rd(CT, d); chk("R1 ctrl cleared", d, 32'h0);

        // R11: entropy changes the stream (same timing otherwise)
        do_reset();
        wr(CT, 32'h1);
        wr(CT, 32'h0);
        idle(40);
        rd(OU, wa);
        do_reset();
        wr(CT, 32'h1);
        wr(EN, 32'hDEAD_BEEF);
        idle(40);
        rd(OU, wb);
        chk("R11 nonzero", {31'b0, (wa != 0 && wb != 0)}, 32'h1);
        chk("R11 differs", {31'b0, (wa != wb)}, 32'h1);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule